// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block controls a power-on self-test. After a start request it runs four external sub-tests one after another and shows which phase it is in as a 3-bit screen-colour code. The four sub-tests are a quick ROM/RAM check with controller set-up, a long memory test, a video/sound interrupt timing check and a processor-variant probe. Each sub-test is a separate unit that the block starts with a one-cycle strobe. The unit answers with a done pulse and its result flags. A per-phase timeout makes sure a silent unit cannot stall the sequence.

While it runs, the block builds a 32-bit result word. Bits 0 to 7 are status bits. Bits 8 to 31 are fault bits. When the sequence ends, the block either stops on red with the pass flag low, or shows green for a fixed time, then pulses a launch strobe and turns the screen black. A configuration bit can drop the long memory test and the timing checks together. The processor probe runs only when no fault has been recorded.

Top module: `post_sequencer`

## Requirements
- R1: After reset the colour code is black (000), the result word is zero, and every start, done, pass and launch output is low.
- R2: A go pulse in the idle state copies the cause inputs into result bits 0 to 2 and the PC-style IO flag into bit 6. It then starts the quick check, with the colour purple (001).
- R3: The long memory test runs with the colour blue (010) and sets status bit 3 when it starts. A failure it reports sets 0x40000.
- R4: The video/sound check follows the long memory test and keeps the colour blue. A video failure sets 0x4000 and a sound failure sets 0x8000.
- R5: The quick check's six fault flags map, from flag 0 to flag 5, onto bits 9, 10, 11, 12, 16 and 17. When any of them is set, the long memory test, the video/sound check and the probe are all skipped.
- R6: When bit 7 of the configuration byte is high at go, the block skips both the long memory test and the video/sound check, sets status bit 5, and goes straight from the quick check to the probe.
- R7: The probe runs with the colour purple and only while no fault bit is set. A report that the variant is present sets status bit 4.
- R8: With any fault bit set at the end, the colour is red (011), done is high and pass is low. The block then holds this state and the result word until reset.
- R9: With no fault bit set at the end, the colour is green (100) for GREEN_CYCLES cycles. Launch then pulses for one cycle while the colour turns black, and done and pass go high.
- R10: When a sub-test does not answer within TIMEOUT cycles, the block records its fault and moves on. The fault bits are 0x1000 for the quick check, 0x40000 for the long test, 0x4000 and 0x8000 together for the video/sound check, and 0x100 for the probe.
- R11: A done pulse from a sub-test whose phase is not active has no effect. A go pulse while the sequence is running also has no effect.
- R12: Start strobes last one cycle and at most one is high at a time. Bit 0 starts the quick check, bit 1 the long test, bit 2 the video/sound check and bit 3 the probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| go_i | input | 1 | Start the self-test (idle only) |
| cause_i | input | 3 | Start cause: power-on, interface, test link |
| pc_io_i | input | 1 | PC-style IO detected |
| cfg_i | input | 8 | Configuration byte; bit 7 disables long and timing tests |
| test_start_o | output | 4 | One-cycle start strobes per sub-test |
| test_done_i | input | 4 | Done pulses per sub-test |
| quick_flt_i | input | 6 | Quick check fault flags |
| long_fail_i | input | 1 | Long memory test failed |
| vid_fail_i | input | 1 | Video interrupt timing failed |
| snd_fail_i | input | 1 | Sound interrupt timing failed |
| probe_found_i | input | 1 | Processor variant present |
| colour_o | output | 3 | Screen colour code |
| result_o | output | 32 | Status and fault word |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Finished without fault |
| launch_o | output | 1 | One-cycle launch strobe on pass |

## Verification
The assertions check the following on every cycle:
- the start strobes are one-hot and last a single cycle;
- the long test always starts under a blue screen;
- the probe never starts once a fault bit is set;
- the long test never starts when the disable bit was captured;
- a failed end always shows red with a frozen result word;
- launch never lasts beyond one cycle.

Some behaviours only the directed scenarios can show:
- the exact bit each sub-test fault lands on;
- the choice of which phases are skipped after each fault;
- the length of the green period;
- the timeout recovery for each phase;
- that stray done and go pulses leave the result untouched.

// File: rtl/post_sequencer.sv
module post_sequencer #(
  parameter int TIMEOUT      = 100000,
  parameter int GREEN_CYCLES = 16,
  localparam int TW = $clog2((TIMEOUT > GREEN_CYCLES ? TIMEOUT : GREEN_CYCLES) + 1) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic [2:0]  cause_i,
  input  logic        pc_io_i,
  input  logic [7:0]  cfg_i,
  output logic [3:0]  test_start_o,
  input  logic [3:0]  test_done_i,
  input  logic [5:0]  quick_flt_i,
  input  logic        long_fail_i,
  input  logic        vid_fail_i,
  input  logic        snd_fail_i,
  input  logic        probe_found_i,
  output logic [2:0]  colour_o,
  output logic [31:0] result_o,
  output logic        done_o,
  output logic        pass_o,
  output logic        launch_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_QUICK, S_LONG, S_TIMING, S_PROBE, S_GREEN, S_RUN, S_FAIL
  } state_t;

  localparam logic [2:0] C_BLACK  = 3'b000;
  localparam logic [2:0] C_PURPLE = 3'b001;
  localparam logic [2:0] C_BLUE   = 3'b010;
  localparam logic [2:0] C_RED    = 3'b011;
  localparam logic [2:0] C_GREEN  = 3'b100;

  state_t      state_q, state_d;
  logic [31:0] res_q, res_d, add;
  logic [TW-1:0] tmr_q;
  logic [3:0]  start_q, start_d;
  logic        launch_q, dis_q, fin, tmo, flt_n;

  assign tmo = (tmr_q == TW'(TIMEOUT - 1));

  always_comb begin
    add = '0;
    fin = 1'b0;
    case (state_q)
      S_QUICK:
        if (test_done_i[0]) begin
          fin = 1'b1;
          add[12:9]  = quick_flt_i[3:0];
          add[17:16] = quick_flt_i[5:4];
        end else if (tmo) begin
          fin = 1'b1;
          add[12] = 1'b1;
        end
      S_LONG:
        if (test_done_i[1]) begin
          fin = 1'b1;
          add[18] = long_fail_i;
        end else if (tmo) begin
          fin = 1'b1;
          add[18] = 1'b1;
        end
      S_TIMING:
        if (test_done_i[2]) begin
          fin = 1'b1;
          add[14] = vid_fail_i;
          add[15] = snd_fail_i;
        end else if (tmo) begin
          fin = 1'b1;
          add[15:14] = 2'b11;
        end
      S_PROBE:
        if (test_done_i[3]) begin
          fin = 1'b1;
          add[4] = probe_found_i;
        end else if (tmo) begin
          fin = 1'b1;
          add[8] = 1'b1;
        end
      default: ;
    endcase
  end

  assign flt_n = |(res_q[31:8] | add[31:8]);

  always_comb begin
    state_d = state_q;
    start_d = '0;
    res_d   = res_q | add;
    case (state_q)
      S_IDLE:
        if (go_i) begin
          state_d = S_QUICK;
          start_d = 4'b0001;
          res_d   = {25'd0, pc_io_i, cfg_i[7], 2'b00, cause_i};
        end
      S_QUICK:
        if (fin) begin
          if (flt_n) state_d = S_FAIL;
          else if (dis_q) begin
            state_d = S_PROBE;
            start_d = 4'b1000;
          end else begin
            state_d  = S_LONG;
            start_d  = 4'b0010;
            res_d[3] = 1'b1;
          end
        end
      S_LONG:
        if (fin) begin
          state_d = S_TIMING;
          start_d = 4'b0100;
        end
      S_TIMING:
        if (fin) begin
          if (flt_n) state_d = S_FAIL;
          else begin
            state_d = S_PROBE;
            start_d = 4'b1000;
          end
        end
      S_PROBE:
        if (fin) state_d = flt_n ? S_FAIL : S_GREEN;
      S_GREEN:
        if (tmr_q == TW'(GREEN_CYCLES - 1)) state_d = S_RUN;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      res_q    <= '0;
      tmr_q    <= '0;
      start_q  <= '0;
      launch_q <= 1'b0;
      dis_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      res_q    <= res_d;
      start_q  <= start_d;
      launch_q <= (state_q == S_GREEN) && (state_d == S_RUN);
      tmr_q    <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
      if (state_q == S_IDLE && go_i) dis_q <= cfg_i[7];
    end
  end

  always_comb begin
    case (state_q)
      S_QUICK, S_PROBE: colour_o = C_PURPLE;
      S_LONG, S_TIMING: colour_o = C_BLUE;
      S_GREEN:          colour_o = C_GREEN;
      S_FAIL:           colour_o = C_RED;
      default:          colour_o = C_BLACK;
    endcase
  end

  assign test_start_o = start_q;
  assign result_o     = res_q;
  assign done_o       = (state_q == S_RUN) || (state_q == S_FAIL);
  assign pass_o       = (state_q == S_RUN);
  assign launch_o     = launch_q;

  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(test_start_o)); // R12
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|test_start_o) |=> (test_start_o != $past(test_start_o))); // R12
  AST_LONG_BLUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_o[1] |-> (colour_o == C_BLUE && result_o[3])); // R3
  AST_PROBE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_o[3] |-> (result_o[31:8] == '0)); // R7
  AST_DISABLE_SKIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_start_o[1] || test_start_o[2]) |-> !result_o[5]); // R6
  AST_FAIL_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (colour_o == C_RED && result_o[31:8] != '0)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(result_o) && done_o)); // R8
  AST_LAUNCH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (pass_o && colour_o == C_BLACK) ##1 !launch_o); // R9

endmodule

// File: tb/post_sequencer_tb_top.sv
module post_sequencer_tb_top;
  localparam int TMO = 50;
  localparam int GRN = 4;

  logic        clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [2:0]  cause = '0;
  logic        pc_io = 1'b0;
  logic [7:0]  cfg = '0;
  logic [3:0]  start, rsp_done = '0, stray = '0;
  logic [5:0]  qk = '0;
  logic        lf = 1'b0, vf = 1'b0, sf = 1'b0, pf = 1'b0;
  logic [2:0]  colour;
  logic [31:0] result;
  logic        done, pass, launch;
  logic [3:0]  rsp_en = 4'hF;
  int          saw [4];
  logic [2:0]  col [4];
  int          cnt [4];
  int          green_n = 0;
  int          nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  post_sequencer #(.TIMEOUT(TMO), .GREEN_CYCLES(GRN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .cause_i(cause), .pc_io_i(pc_io),
    .cfg_i(cfg), .test_start_o(start), .test_done_i(rsp_done | stray),
    .quick_flt_i(qk), .long_fail_i(lf), .vid_fail_i(vf), .snd_fail_i(sf),
    .probe_found_i(pf), .colour_o(colour), .result_o(result), .done_o(done),
    .pass_o(pass), .launch_o(launch));

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        for (int i = 0; i < 4; i++) begin saw[i] = 0; col[i] = '0; cnt[i] = 0; end
        rsp_done = '0;
        green_n = 0;
      end else begin
        if (colour == 3'b100) green_n++;
        for (int i = 0; i < 4; i++) begin
          if (rsp_done[i]) rsp_done[i] = 1'b0;
          else if (cnt[i] > 0) begin
            cnt[i]--;
            if (cnt[i] == 0) rsp_done[i] = 1'b1;
          end
          if (start[i]) begin
            saw[i]++;
            col[i] = colour;
            if (rsp_en[i]) cnt[i] = 3;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] c, input logic p, input logic [7:0] g,
                       input logic [5:0] q, input logic l, input logic v,
                       input logic s, input logic f, input logic [3:0] en);
    rst_n = 1'b0;
    cause = c; pc_io = p; cfg = g; qk = q; lf = l; vf = v; sf = s; pf = f; rsp_en = en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, req, {31'd0, done}, 32'd1);
  endtask

  task automatic expect_fail(input string req, input logic [31:0] exp);
    wait_done(req);
    chk(result == exp, req, result, exp);
    chk(colour == 3'b011 && !pass && !launch, "R8 red end", {29'd0, colour}, 32'd3);
    repeat (5) @(negedge clk);
    chk(result == exp && colour == 3'b011, "R8 hold", result, exp);
  endtask

  task automatic expect_pass(input string req, input logic [31:0] exp);
    wait_done(req);
    chk(launch && pass && colour == 3'b000, "R9 launch", {launch, pass, colour}, 5'b11000);
    chk(green_n == GRN, "R9 green length", green_n, GRN);
    chk(result == exp, req, result, exp);
    @(negedge clk);
    chk(!launch && pass, "R9 launch single", {31'd0, launch}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(colour == 3'b000 && result == '0, "R1 reset colour/result", result, 32'd0);
    chk(start == '0 && !done && !pass && !launch, "R1 reset outputs", {28'd0, start}, 32'd0);
  endtask

  task automatic t_full_pass();
    setup(3'b001, 1'b1, 8'h00, '0, 0, 0, 0, 1, 4'hF);
    chk(saw[0] == 1 && col[0] == 3'b001, "R2 quick purple", {29'd0, col[0]}, 32'd1);
    expect_pass("R2 R3 R7 full pass result", 32'h0000_0059);
    chk(saw[1] == 1 && col[1] == 3'b010, "R3 long blue", {29'd0, col[1]}, 32'd2);
    chk(saw[2] == 1 && col[2] == 3'b010, "R4 timing blue", {29'd0, col[2]}, 32'd2);
    chk(saw[3] == 1 && col[3] == 3'b001, "R7 probe purple", {29'd0, col[3]}, 32'd1);
  endtask

  task automatic t_quick_faults();
    setup(3'b100, 1'b0, 8'h00, 6'b101010, 0, 0, 0, 1, 4'hF);
    expect_fail("R5 quick map odd", 32'h0002_1404);
    chk(saw[1] == 0 && saw[2] == 0 && saw[3] == 0, "R5 skips", saw[1] + saw[2] + saw[3], 0);
    setup(3'b001, 1'b0, 8'h00, 6'b010101, 0, 0, 0, 1, 4'hF);
    expect_fail("R5 quick map even", 32'h0001_0A01);
  endtask

  task automatic t_long_video();
    setup(3'b001, 1'b0, 8'h00, '0, 1, 1, 0, 1, 4'hF);
    expect_fail("R3 R4 long+video fault", 32'h0004_4009);
    chk(saw[2] == 1 && saw[3] == 0, "R7 probe skipped", saw[3], 0);
    setup(3'b001, 1'b0, 8'h7F, '0, 0, 0, 1, 0, 4'hF);
    expect_fail("R4 sound fault", 32'h0000_8009);
  endtask

  task automatic t_disable();
    setup(3'b001, 1'b0, 8'h80, '0, 0, 0, 0, 0, 4'hF);
    expect_pass("R6 disabled pass", 32'h0000_0021);
    chk(saw[1] == 0 && saw[2] == 0 && saw[3] == 1, "R6 long/timing skipped", saw[1] + saw[2], 0);
  endtask

  task automatic t_timeouts();
    setup(3'b010, 1'b0, 8'h00, '0, 0, 0, 0, 0, 4'b1110);
    expect_fail("R10 quick timeout", 32'h0000_1002);
    setup(3'b001, 1'b0, 8'h00, '0, 0, 0, 0, 0, 4'b1101);
    expect_fail("R10 long timeout", 32'h0004_0009);
    setup(3'b001, 1'b0, 8'h00, '0, 0, 0, 0, 0, 4'b1011);
    expect_fail("R10 timing timeout", 32'h0000_C009);
    setup(3'b001, 1'b0, 8'h00, '0, 0, 0, 0, 1, 4'b0111);
    expect_fail("R10 probe timeout", 32'h0000_0109);
  endtask

  task automatic t_ignored();
    setup(3'b001, 1'b0, 8'h00, '0, 0, 0, 0, 1, 4'hF);
    stray = 4'b1110;
    cause = 3'b100;
    go = 1'b1;
    @(negedge clk);
    stray = '0;
    go = 1'b0;
    pf = 1'b0;
    chk(result == 32'h1 && colour == 3'b001, "R11 stray ignored", result, 32'h1);
    expect_pass("R11 final result", 32'h0000_0009);
    chk(saw[0] == 1, "R11 go while busy", saw[0], 1);
  endtask

  initial begin
    t_reset();
    t_full_pass();
    t_quick_faults();
    t_long_video();
    t_disable();
    t_timeouts();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule